// File: doc/BRIEF.md
# Disciplined PPS time-tag counter

This block generates the timestamp given to each detected event. It keeps two counters. A seconds counter advances once per second. A sub-second counter advances on every cycle of the 10 MHz reference, which also clocks the block. A timestamp is the two counters joined together, and it is captured when an event strobe arrives.

The block has two sources for the one-second boundary: a local oscillator's pulse-per-second and the spacecraft's GPS-derived pulse-per-second. While GPS lock is reported, every second boundary follows the rising edge of the spacecraft pulse, so local time is pulled back into line once per second. When lock is lost, the block switches to the local pulse and keeps counting with no gap. If neither pulse arrives for too long, the block counts seconds by wrapping the sub-second counter and raises a missing-pulse flag. A status output gives the number of seconds since the last locked alignment, so software can judge how far the timestamps may have drifted.

Both pulses and the lock flag are asynchronous. Each passes through a two-flop synchroniser before use. The event strobe is synchronous to the 10 MHz clock.

Top module: `pps_timetag`

## Requirements
- R1: While reset is low, all of the following hold: `stamp` reads 0, `stamp_vld` is 0, `pps_missing` is 0, `lock_ok` is 0, and `since_align` is all ones.
- R2: The sub-second count rises by one on every clock cycle that is not a second boundary.
- R3: A rising edge on the selected pulse input is acted on at the third rising clock edge after the input goes high. At that edge the seconds count rises by one and the sub-second count becomes 0.
- R4: While the synchronised lock flag is 1, only rising edges of `sc_pps` mark second boundaries. Edges of `loc_pps` have no effect.
- R5: While the synchronised lock flag is 0, only rising edges of `loc_pps` mark second boundaries. Edges of `sc_pps` have no effect.
- R6: `lock_ok` follows `gps_lock` through two flops, so a change shows two clock edges later.
- R7: `pps_missing` goes to 1 once MISS_LIMIT clock cycles have passed with no accepted pulse edge. It returns to 0 at the next accepted edge.
- R8: While `pps_missing` is 1, a sub-second count of TICKS-1 or more is followed by 0, and the seconds count rises by one at that same edge.
- R9: When `evt_stb` is sampled high at a clock edge, `stamp` takes the seconds and sub-second values from just before that edge, both from the same cycle. The seconds go in the upper SEC_W bits and the sub-seconds in the lower SUB_W bits. `stamp_vld` is 1 for that one cycle. At all other times `stamp` holds its value.
- R10: An accepted edge while locked clears `since_align` to 0. Every other second boundary raises it by one. It stops at its maximum value.
- R11: A pulse input that stays high produces only one second boundary. Only rising edges count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_pps | input | 1 | Local oscillator pulse-per-second, asynchronous |
| sc_pps | input | 1 | Spacecraft GPS pulse-per-second, asynchronous |
| gps_lock | input | 1 | GPS lock flag, asynchronous |
| evt_stb | input | 1 | Event strobe, synchronous to clk |
| stamp | output | SEC_W+SUB_W | Captured timestamp, seconds in the upper bits |
| stamp_vld | output | 1 | One-cycle pulse that marks a new capture |
| pps_missing | output | 1 | No accepted pulse for MISS_LIMIT cycles |
| lock_ok | output | 1 | Synchronised lock flag |
| since_align | output | SINCE_W | Seconds since the last locked alignment, saturating |

## Verification
The assertions assume that the event strobe is a clean synchronous signal. They also assume that pulse inputs stay high for at least one clock and are spaced far apart compared with the synchroniser depth, so that each edge becomes one accepted boundary. The stimulus keeps pulse widths between one and four cycles and periods near TICKS. It also inserts gaps of three periods to drive the missing-pulse path. Lock changes at random points relative to the pulses, which exercises the handover between the two pulse sources.

// File: rtl/pps_timetag.sv
module pps_timetag #(
  parameter int SEC_W      = 28,
  parameter int SUB_W      = 24,
  parameter int TICKS      = 10_000_000,
  parameter int MISS_LIMIT = 10_000_100,
  parameter int SINCE_W    = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   loc_pps,
  input  logic                   sc_pps,
  input  logic                   gps_lock,
  input  logic                   evt_stb,
  output logic [SEC_W+SUB_W-1:0] stamp,
  output logic                   stamp_vld,
  output logic                   pps_missing,
  output logic                   lock_ok,
  output logic [SINCE_W-1:0]     since_align
);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [SUB_W-1:0]   SUB_LAST  = SUB_W'(TICKS - 1);
  localparam logic [MISS_W-1:0]  MISS_TOP  = MISS_W'(MISS_LIMIT);
  localparam logic [SINCE_W-1:0] SINCE_TOP = '1;

  logic [2:0]         lp_q, sp_q;
  logic [1:0]         lk_q;
  logic [SEC_W-1:0]   sec_q;
  logic [SUB_W-1:0]   sub_q;
  logic [MISS_W-1:0]  miss_q;
  logic               acc, wrap, tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lp_q <= '0;
      sp_q <= '0;
      lk_q <= '0;
    end else begin
      lp_q <= {lp_q[1:0], loc_pps};
      sp_q <= {sp_q[1:0], sc_pps};
      lk_q <= {lk_q[0], gps_lock};
    end
  end

  assign lock_ok     = lk_q[1];
  assign acc         = lock_ok ? (sp_q[1] & ~sp_q[2]) : (lp_q[1] & ~lp_q[2]);
  assign pps_missing = (miss_q == MISS_TOP);
  assign wrap        = pps_missing && (sub_q >= SUB_LAST);
  assign tick        = acc | wrap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q       <= '0;
      sub_q       <= '0;
      miss_q      <= '0;
      since_align <= SINCE_TOP;
    end else begin
      sub_q <= tick ? '0 : sub_q + 1'b1;
      if (tick) sec_q <= sec_q + 1'b1;
      if (acc) miss_q <= '0;
      else if (!pps_missing) miss_q <= miss_q + 1'b1;
      if (acc && lock_ok) since_align <= '0;
      else if (tick && since_align != SINCE_TOP) since_align <= since_align + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp     <= '0;
      stamp_vld <= 1'b0;
    end else begin
      stamp_vld <= evt_stb;
      if (evt_stb) stamp <= {sec_q, sub_q};
    end
  end
endmodule

// File: rtl/pps_timetag_chk.sv
module pps_timetag_chk #(
  parameter int SEC_W   = 28,
  parameter int SUB_W   = 24,
  parameter int SINCE_W = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   evt_stb,
  input logic                   acc,
  input logic                   lock_ok,
  input logic                   pps_missing,
  input logic                   stamp_vld,
  input logic [SEC_W+SUB_W-1:0] stamp,
  input logic [SEC_W-1:0]       sec,
  input logic [SUB_W-1:0]       sub,
  input logic [SINCE_W-1:0]     since
);
  // R3
  edge_clears_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (sub == '0) && (sec == $past(sec) + 1'b1));

  // R2
  sec_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc && !pps_missing) |=> $stable(sec));

  // R9
  capture_coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_stb |=> stamp_vld && (stamp == {$past(sec), $past(sub)}));

  // R9
  stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_stb |=> !stamp_vld && $stable(stamp));

  // R7
  missing_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !pps_missing);

  // R10
  since_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && lock_ok) |=> (since == '0));

  // R10
  since_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && lock_ok) |=> (since >= $past(since)));
endmodule

bind pps_timetag pps_timetag_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W), .SINCE_W(SINCE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_stb(evt_stb), .acc(acc), .lock_ok(lock_ok),
  .pps_missing(pps_missing), .stamp_vld(stamp_vld), .stamp(stamp),
  .sec(sec_q), .sub(sub_q), .since(since_align)
);

// File: tb/pps_timetag_bench.sv
module pps_timetag_bench;
  localparam int T  = 40;
  localparam int ML = 48;
  localparam int SW = 3;
  localparam logic [SW-1:0] SMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loc_pps = 1'b0, sc_pps = 1'b0, gps_lock = 1'b0, evt_stb = 1'b0;
  logic [51:0]   stamp;
  logic          stamp_vld, pps_missing, lock_ok;
  logic [SW-1:0] since_align;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pps_timetag #(.SEC_W(28), .SUB_W(24), .TICKS(T), .MISS_LIMIT(ML), .SINCE_W(SW)) u_pps_timetag (
    .clk(clk), .rst_n(rst_n), .loc_pps(loc_pps), .sc_pps(sc_pps), .gps_lock(gps_lock),
    .evt_stb(evt_stb), .stamp(stamp), .stamp_vld(stamp_vld), .pps_missing(pps_missing),
    .lock_ok(lock_ok), .since_align(since_align)
  );

  logic [27:0]   m_sec;
  logic [23:0]   m_sub;
  int            m_miss;
  logic [SW-1:0] m_since;
  logic [51:0]   m_stamp;
  logic          m_vld;
  logic [2:0]    m_lp, m_sp;
  logic [1:0]    m_lk;

  function automatic logic [SW-1:0] sat_inc(input logic [SW-1:0] v);
    return (v == SMAX) ? v : v + 1'b1;
  endfunction

  task automatic model_reset();
    m_sec = '0; m_sub = '0; m_miss = 0; m_since = SMAX;
    m_stamp = '0; m_vld = 1'b0; m_lp = '0; m_sp = '0; m_lk = '0;
  endtask

  task automatic model_step(input logic lp, input logic sp, input logic lk, input logic ev);
    logic lkd, acc, miss;
    lkd  = m_lk[1];
    acc  = lkd ? (m_sp[1] & ~m_sp[2]) : (m_lp[1] & ~m_lp[2]);
    miss = (m_miss == ML);
    m_vld = ev;
    if (ev) m_stamp = {m_sec, m_sub};
    if (acc) begin
      m_sec = m_sec + 1'b1; m_sub = '0; m_miss = 0;
      m_since = lkd ? '0 : sat_inc(m_since);
    end else begin
      if (!miss) m_miss = m_miss + 1;
      if (miss && m_sub >= 24'(T - 1)) begin
        m_sub = '0; m_sec = m_sec + 1'b1; m_since = sat_inc(m_since);
      end else m_sub = m_sub + 1'b1;
    end
    m_lp = {m_lp[1:0], lp};
    m_sp = {m_sp[1:0], sp};
    m_lk = {m_lk[0], lk};
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(lock_ok === m_lk[1], tag, "R6 lock_ok", 64'(lock_ok), 64'(m_lk[1]));
    chk(pps_missing === (m_miss == ML), tag, "R7 pps_missing", 64'(pps_missing), 64'(m_miss == ML));
    chk(since_align === m_since, tag, "R10 since_align", 64'(since_align), 64'(m_since));
    chk(stamp_vld === m_vld, tag, "R9 stamp_vld", 64'(stamp_vld), 64'(m_vld));
    chk(stamp === m_stamp, tag, "R9 stamp", 64'(stamp), 64'(m_stamp));
  endtask

  task automatic cyc(input logic lp, input logic sp, input logic lk, input logic ev, input string tag);
    loc_pps = lp; sc_pps = sp; gps_lock = lk; evt_stb = ev;
    model_step(lp, sp, lk, ev);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int seed, ph, per, w, off, seg;
    logic lk, lp, sp;
    seed = $urandom(13579);
    model_reset();
    repeat (4) @(negedge clk);
    compare("R1 reset");
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, "R2 free count");
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 1, "R3 R5 local edge");
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1, "R3 after edge");
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 1, "R5 sc ignored");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, "R5 after sc");
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, (i % 3) == 0, "R11 held high");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, "R6 lock rise");
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 1, "R4 local ignored");
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 1, "R4 after local");
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 1, "R4 R10 sc edge");
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 1, "R10 aligned");
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, "R6 lock fall");
    for (int i = 0; i < 400; i++) cyc(0, 0, 0, (i % 7) == 0, "R7 R8 coast");
    for (int i = 0; i < 2; i++) cyc(1, 0, 0, 1, "R7 recover");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 1, "R7 recovered");

    ph = 0; per = T; w = 2; off = 2; seg = 0; lk = 1'b0;
    for (int i = 0; i < 8000; i++) begin
      if (seg == 0) begin
        lk = 1'($urandom % 2);
        seg = 200 + int'($urandom % 400);
      end
      seg--;
      lp = (ph < w);
      sp = (ph >= off) && (ph < off + w);
      cyc(lp, sp, lk, ($urandom % 5) == 0, "random R2 R3 R4 R5 R8");
      ph++;
      if (ph >= per) begin
        ph  = 0;
        per = (($urandom % 6) == 0) ? 3 * T : T - 3 + int'($urandom % 7);
        w   = 1 + int'($urandom % 4);
        off = int'($urandom % 5);
      end
    end
    summary();
  end
endmodule